// File: doc/BRIEF.md
# Load-Load Ordering Violation Queue

This block keeps a small associative record of loads that have finished their memory access while older loads are still outstanding. Another core can write a line between two loads of this core that ran out of order. When that happens the local data cache gives the line up, and the younger load may then hold a stale value that the older load does not see. The queue catches this case. The data cache reports each line it gives up on one of several release ports. Every stored load whose compressed line address matches a reported line is then flagged as released.

The load pipeline presents each load to the queue with a valid/ready handshake. A single request carries two operations. It is a check: the queue answers one cycle after the handshake and flags a violation when a younger, released load to the same address is stored. It can also be an enqueue: the load is stored in the lowest free slot when older loads are still pending and the load has not been killed. Loads that bypass the cache are stored already released. Entries are freed when the oldest-uncommitted pointer moves past them, and by a pipeline redirect, which frees every entry younger than the redirect point.

Top module: `ldld_order_queue`

## Requirements
- R1: After reset no slot is occupied, `req_ready` is high and `resp_valid` is low.
- R2: A load is stored only on a cycle where `req_valid` and `req_ready` are both high, `req_older_pending` is high, `req_kill` is low, and no redirect blocks it; `enq_fire` is high on exactly those cycles.
- R3: A stored load goes to the lowest-numbered free slot, reported on `enq_slot` in the same cycle.
- R4: `req_ready` is low exactly when all DEPTH slots are occupied.
- R5: The violation flag is high when an occupied slot holds a load younger than the requesting load, with an equal 16-bit address and its released bit set. The state is taken as it stood in the handshake cycle.
- R6: `resp_valid` is high for one cycle, in the cycle after each handshake, and at no other time.
- R7: A release on any of the NUM_REL ports sets the released bit of every occupied slot with the same address. Checks handshaken from the next cycle on see it.
- R8: A load stored with `req_nc` high is released from the moment it is stored.
- R9: If a release and an enqueue of the same address fall in the same cycle, the new entry is stored released.
- R10: A slot is freed on the clock edge where its load is older than `oldest_rob`.
- R11: `redirect_valid` at one edge frees every entry strictly younger than `redirect_rob` at the following edge. In the cycle between those two edges, loads younger than the redirect point are not stored.
- R12: Pointers are 7 bits, with bit 6 as the wrap flag and bits 5:0 as the index. A is younger than B when the flags are equal and A's index is larger, or when the flags differ and A's index is smaller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request valid |
| req_ready | output | 1 | A free slot exists |
| req_rob | input | 7 | Reorder pointer of the load (wrap flag in bit 6) |
| req_addr | input | 16 | Compressed line address of the load |
| req_nc | input | 1 | Load bypasses the cache |
| req_older_pending | input | 1 | Older loads are still uncompleted |
| req_kill | input | 1 | Load has been flushed |
| enq_fire | output | 1 | Load is stored this cycle |
| enq_slot | output | log2(DEPTH) | Slot receiving the load |
| resp_valid | output | 1 | Check response valid |
| resp_violation | output | 1 | Ordering violation found; flush after this load |
| rel_valid | input | NUM_REL | Release notification valid, one per source |
| rel_addr | input | NUM_REL x 16 | Released line address, one per source |
| oldest_rob | input | 7 | Pointer of the oldest uncommitted load |
| redirect_valid | input | 1 | Pipeline redirect |
| redirect_rob | input | 7 | Redirect point pointer |

## Verification
The bench builds the queue with DEPTH=4 and NUM_REL=3. A four-slot queue fills within a few loads, so back-pressure, lowest-slot reuse after retirement and full-queue stalls all happen often under random traffic. Three release sources let releases on several ports land in the same cycle as a check or an enqueue. The addresses come from a pool of four values and the request pointers fall within 24 of the oldest pointer, which keeps address matches and age comparisons across the pointer wrap frequent.

// File: rtl/ldld_pkg.sv
package ldld_pkg;
  localparam int LDQ_ROB_IDX_W = 6;
  localparam int LDQ_ROB_PTR_W = LDQ_ROB_IDX_W + 1;
  localparam int LDQ_ADDR_W    = 16;

  typedef struct packed {
    logic                     wrap;
    logic [LDQ_ROB_IDX_W-1:0] idx;
  } rob_ptr_t;

  typedef logic [LDQ_ADDR_W-1:0] line_addr_t;

  // a is younger than b in program order
  function automatic logic rob_is_younger(rob_ptr_t a, rob_ptr_t b);
    if (a.wrap == b.wrap) return a.idx > b.idx;
    return a.idx < b.idx;
  endfunction
endpackage

// File: rtl/ldq_slot_alloc.sv
module ldq_slot_alloc #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic [DEPTH-1:0] occ,
  output logic             any_free,
  output logic [IDX_W-1:0] slot
);
  function automatic logic [IDX_W-1:0] lowest_clear(logic [DEPTH-1:0] v);
    logic [IDX_W-1:0] pick;
    pick = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!v[i]) pick = IDX_W'(i);
    end
    return pick;
  endfunction

  assign any_free = |(~occ);
  assign slot     = lowest_clear(occ);
endmodule

// File: rtl/ldq_entry_store.sv
module ldq_entry_store
  import ldld_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int NUM_REL = 3,
  parameter int IDX_W   = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [IDX_W-1:0]                    wr_slot,
  input  rob_ptr_t                            wr_rob,
  input  line_addr_t                          wr_addr,
  input  logic                                wr_nc,
  input  logic [NUM_REL-1:0]                  rel_valid,
  input  logic [NUM_REL-1:0][LDQ_ADDR_W-1:0]  rel_addr,
  input  rob_ptr_t                            oldest_ptr,
  input  logic                                flush_en,
  input  rob_ptr_t                            flush_ptr,
  output logic [DEPTH-1:0]                    occ,
  output logic [DEPTH-1:0]                    released,
  output rob_ptr_t [DEPTH-1:0]                ent_rob,
  output line_addr_t [DEPTH-1:0]              ent_addr
);
  function automatic logic addr_released(
    line_addr_t                          a,
    logic [NUM_REL-1:0]                  v,
    logic [NUM_REL-1:0][LDQ_ADDR_W-1:0]  ra
  );
    logic hit;
    hit = 1'b0;
    for (int p = 0; p < NUM_REL; p++) begin
      if (v[p] && ra[p] == a) hit = 1'b1;
    end
    return hit;
  endfunction

  logic new_released;
  assign new_released = wr_nc || addr_released(wr_addr, rel_valid, rel_addr);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic       occ_r;
    logic       rel_r;
    rob_ptr_t   rob_r;
    line_addr_t addr_r;
    logic       wr_here;
    logic       retire_hit;
    logic       flush_hit;
    logic       snoop_hit;

    assign wr_here    = wr_en && (wr_slot == IDX_W'(g));
    assign retire_hit = occ_r && rob_is_younger(oldest_ptr, rob_r);
    assign flush_hit  = flush_en && occ_r && rob_is_younger(rob_r, flush_ptr);
    assign snoop_hit  = occ_r && addr_released(addr_r, rel_valid, rel_addr);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        occ_r  <= 1'b0;
        rel_r  <= 1'b0;
        rob_r  <= '0;
        addr_r <= '0;
      end else if (wr_here) begin
        occ_r  <= 1'b1;
        rel_r  <= new_released;
        rob_r  <= wr_rob;
        addr_r <= wr_addr;
      end else begin
        if (retire_hit || flush_hit) occ_r <= 1'b0;
        if (snoop_hit) rel_r <= 1'b1;
      end
    end

    assign occ[g]      = occ_r;
    assign released[g] = rel_r;
    assign ent_rob[g]  = rob_r;
    assign ent_addr[g] = addr_r;
  end
endmodule

// File: rtl/ldq_viol_check.sv
module ldq_viol_check
  import ldld_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   chk_fire,
  input  rob_ptr_t               chk_rob,
  input  line_addr_t             chk_addr,
  input  logic [DEPTH-1:0]       occ,
  input  logic [DEPTH-1:0]       released,
  input  rob_ptr_t [DEPTH-1:0]   ent_rob,
  input  line_addr_t [DEPTH-1:0] ent_addr,
  output logic [DEPTH-1:0]       hit_mask,
  output logic                   resp_valid,
  output logic                   resp_violation
);
  function automatic logic entry_hits(
    logic occ_b, logic rel_b, rob_ptr_t e_rob, line_addr_t e_addr,
    rob_ptr_t q_rob, line_addr_t q_addr
  );
    return occ_b && rel_b && (e_addr == q_addr) && rob_is_younger(e_rob, q_rob);
  endfunction

  logic [DEPTH-1:0] mask_q;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      hit_mask[i] = entry_hits(occ[i], released[i], ent_rob[i], ent_addr[i],
                               chk_rob, chk_addr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      mask_q     <= '0;
    end else begin
      resp_valid <= chk_fire;
      mask_q     <= chk_fire ? hit_mask : '0;
    end
  end

  assign resp_violation = resp_valid && (|mask_q);
endmodule

// File: rtl/ldld_order_queue.sv
module ldld_order_queue
  import ldld_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int NUM_REL = 3,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_valid,
  output logic                               req_ready,
  input  logic [LDQ_ROB_PTR_W-1:0]           req_rob,
  input  logic [LDQ_ADDR_W-1:0]              req_addr,
  input  logic                               req_nc,
  input  logic                               req_older_pending,
  input  logic                               req_kill,
  output logic                               enq_fire,
  output logic [IDX_W-1:0]                   enq_slot,
  output logic                               resp_valid,
  output logic                               resp_violation,
  input  logic [NUM_REL-1:0]                 rel_valid,
  input  logic [NUM_REL-1:0][LDQ_ADDR_W-1:0] rel_addr,
  input  logic [LDQ_ROB_PTR_W-1:0]           oldest_rob,
  input  logic                               redirect_valid,
  input  logic [LDQ_ROB_PTR_W-1:0]           redirect_rob
);
  // named internal events
  logic                   req_fire;
  logic                   enq_blocked;
  logic                   any_free;
  logic [IDX_W-1:0]       free_slot;
  logic                   redir_pend;
  rob_ptr_t               redir_pt;
  logic [DEPTH-1:0]       occ;
  logic [DEPTH-1:0]       released;
  rob_ptr_t [DEPTH-1:0]   ent_rob;
  line_addr_t [DEPTH-1:0] ent_addr;
  logic [DEPTH-1:0]       hit_mask;

  assign req_ready   = any_free;
  assign req_fire    = req_valid && req_ready;
  assign enq_blocked = redir_pend && rob_is_younger(rob_ptr_t'(req_rob), redir_pt);
  assign enq_fire    = req_fire && req_older_pending && !req_kill && !enq_blocked;
  assign enq_slot    = free_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_pend <= 1'b0;
      redir_pt   <= '0;
    end else begin
      redir_pend <= redirect_valid;
      redir_pt   <= rob_ptr_t'(redirect_rob);
    end
  end

  ldq_slot_alloc #(.DEPTH(DEPTH), .IDX_W(IDX_W)) alloc_i (
    .occ      (occ),
    .any_free (any_free),
    .slot     (free_slot)
  );

  ldq_entry_store #(.DEPTH(DEPTH), .NUM_REL(NUM_REL), .IDX_W(IDX_W)) store_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (enq_fire),
    .wr_slot    (free_slot),
    .wr_rob     (rob_ptr_t'(req_rob)),
    .wr_addr    (req_addr),
    .wr_nc      (req_nc),
    .rel_valid  (rel_valid),
    .rel_addr   (rel_addr),
    .oldest_ptr (rob_ptr_t'(oldest_rob)),
    .flush_en   (redir_pend),
    .flush_ptr  (redir_pt),
    .occ        (occ),
    .released   (released),
    .ent_rob    (ent_rob),
    .ent_addr   (ent_addr)
  );

  ldq_viol_check #(.DEPTH(DEPTH)) check_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .chk_fire       (req_fire),
    .chk_rob        (rob_ptr_t'(req_rob)),
    .chk_addr       (req_addr),
    .occ            (occ),
    .released       (released),
    .ent_rob        (ent_rob),
    .ent_addr       (ent_addr),
    .hit_mask       (hit_mask),
    .resp_valid     (resp_valid),
    .resp_violation (resp_violation)
  );
endmodule

// File: rtl/ldld_order_queue_chk.sv
module ldld_order_queue_chk #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_nc,
  input logic             req_older_pending,
  input logic             req_kill,
  input logic             enq_fire,
  input logic [IDX_W-1:0] enq_slot,
  input logic             resp_valid,
  input logic [DEPTH-1:0] occ,
  input logic [DEPTH-1:0] released
);
  // R6
  resp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> resp_valid);

  // R6
  no_stray_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !resp_valid);

  // R2
  enq_needs_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enq_fire |-> (req_valid && req_ready && req_older_pending && !req_kill));

  // R3
  enq_slot_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enq_fire |-> !occ[enq_slot]);

  // R3
  enq_slot_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enq_fire |=> occ[$past(enq_slot)]);

  // R8
  nc_enq_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_fire && req_nc) |=> released[$past(enq_slot)]);

  // R4
  full_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(occ) == DEPTH) |-> !req_ready);
endmodule

bind ldld_order_queue ldld_order_queue_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) chk_i (
  .clk               (clk),
  .rst_n             (rst_n),
  .req_valid         (req_valid),
  .req_ready         (req_ready),
  .req_nc            (req_nc),
  .req_older_pending (req_older_pending),
  .req_kill          (req_kill),
  .enq_fire          (enq_fire),
  .enq_slot          (enq_slot),
  .resp_valid        (resp_valid),
  .occ               (occ),
  .released          (released)
);

// File: tb/ldld_order_queue_tb_top.sv
module ldld_order_queue_tb_top;
  localparam int DEPTH    = 4;
  localparam int NUM_REL  = 3;
  localparam int IDX_W    = 2;
  localparam int WATCHDOG = 50000;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 req_valid = 1'b0;
  logic                 req_ready;
  logic [6:0]           req_rob = '0;
  logic [15:0]          req_addr = '0;
  logic                 req_nc = 1'b0;
  logic                 req_older_pending = 1'b0;
  logic                 req_kill = 1'b0;
  logic                 enq_fire;
  logic [IDX_W-1:0]     enq_slot;
  logic                 resp_valid;
  logic                 resp_violation;
  logic [NUM_REL-1:0]   rel_valid = '0;
  logic [NUM_REL-1:0][15:0] rel_addr = '0;
  logic [6:0]           oldest_rob = '0;
  logic                 redirect_valid = 1'b0;
  logic [6:0]           redirect_rob = '0;

  always #5 clk = ~clk;

  ldld_order_queue #(.DEPTH(DEPTH), .NUM_REL(NUM_REL)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_rob (req_rob),
    .req_addr (req_addr), .req_nc (req_nc), .req_older_pending (req_older_pending),
    .req_kill (req_kill), .enq_fire (enq_fire), .enq_slot (enq_slot),
    .resp_valid (resp_valid), .resp_violation (resp_violation),
    .rel_valid (rel_valid), .rel_addr (rel_addr), .oldest_rob (oldest_rob),
    .redirect_valid (redirect_valid), .redirect_rob (redirect_rob)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model
  bit        m_occ  [DEPTH];
  bit        m_rel  [DEPTH];
  bit [6:0]  m_rob  [DEPTH];
  bit [15:0] m_addr [DEPTH];
  bit        m_redir;
  bit [6:0]  m_redir_pt;
  bit        obs_enq;

  // modular distance form of the age rule (R12)
  function automatic bit tb_younger(bit [6:0] a, bit [6:0] b);
    bit [6:0] d;
    d = a - b;
    return (d != 7'd0) && (d < 7'd64);
  endfunction

  function automatic bit tb_rel_match(bit [15:0] a);
    for (int p = 0; p < NUM_REL; p++)
      if (rel_valid[p] && rel_addr[p] == a) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin
      m_occ[i] = 0; m_rel[i] = 0; m_rob[i] = '0; m_addr[i] = '0;
    end
    m_redir = 0; m_redir_pt = '0;
  endtask

  // one cycle: entered just after a falling edge with inputs driven
  task automatic step();
    bit full, e_fire, e_enq, e_viol;
    int slot;
    #1;
    full = 1; slot = -1;
    for (int i = 0; i < DEPTH; i++) begin
      if (!m_occ[i]) begin
        full = 0;
        if (slot < 0) slot = i;
      end
    end
    e_fire = req_valid && !full;
    e_enq  = e_fire && req_older_pending && !req_kill &&
             !(m_redir && tb_younger(req_rob, m_redir_pt));
    e_viol = 0;
    if (e_fire)
      for (int i = 0; i < DEPTH; i++)
        if (m_occ[i] && m_rel[i] && m_addr[i] == req_addr && tb_younger(m_rob[i], req_rob))
          e_viol = 1;
    check(32'(req_ready), 32'(!full), "R4 ready");
    check(32'(enq_fire), 32'(e_enq), "R2 enq_fire");
    if (e_enq) check(32'(enq_slot), 32'(slot), "R3 enq_slot");
    obs_enq = enq_fire;
    @(posedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      if (m_occ[i]) begin
        if (tb_rel_match(m_addr[i])) m_rel[i] = 1;
        if (tb_younger(oldest_rob, m_rob[i]) || (m_redir && tb_younger(m_rob[i], m_redir_pt)))
          m_occ[i] = 0;
      end
    end
    if (e_enq) begin
      m_occ[slot] = 1; m_rob[slot] = req_rob; m_addr[slot] = req_addr;
      m_rel[slot] = req_nc || tb_rel_match(req_addr);
    end
    m_redir = redirect_valid; m_redir_pt = redirect_rob;
    @(negedge clk);
    check(32'(resp_valid), 32'(e_fire), "R6 resp_valid");
    check(32'(resp_violation), 32'(e_viol), "R5 violation");
  endtask

  task automatic idle_inputs();
    req_valid = 0; req_older_pending = 0; req_kill = 0; req_nc = 0;
    rel_valid = '0; redirect_valid = 0;
  endtask

  task automatic do_enq(input bit [6:0] rob, input bit [15:0] addr, input bit nc);
    req_valid = 1; req_rob = rob; req_addr = addr; req_nc = nc; req_older_pending = 1;
    step();
    idle_inputs();
  endtask

  task automatic do_query(input bit [6:0] rob, input bit [15:0] addr, output bit viol);
    req_valid = 1; req_rob = rob; req_addr = addr; req_older_pending = 0;
    step();
    viol = resp_violation;
    idle_inputs();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R6 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit v;
    bit [15:0] pool [4];
    pool[0] = 16'h1234; pool[1] = 16'hbeef; pool[2] = 16'h0040; pool[3] = 16'h7f01;
    void'($urandom(32'h2b5e));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1
    check(32'(req_ready), 32'd1, "R1 ready after reset");
    check(32'(resp_valid), 32'd0, "R1 resp_valid after reset");
    check(32'(enq_fire), 32'd0, "R1 no enqueue after reset");
    @(negedge clk);

    // R8: non-cacheable load is released on entry
    do_enq(7'd5, 16'haaaa, 1'b1);
    do_query(7'd3, 16'haaaa, v);
    check(32'(v), 32'd1, "R8 nc entry released");
    do_query(7'd7, 16'haaaa, v);
    check(32'(v), 32'd0, "R5 older entry ignored");

    // R7: release sets matching entries
    do_enq(7'd6, 16'hbbbb, 1'b0);
    do_query(7'd4, 16'hbbbb, v);
    check(32'(v), 32'd0, "R7 not yet released");
    rel_valid = 3'b100; rel_addr[2] = 16'hbbbb;
    step();
    idle_inputs();
    do_query(7'd4, 16'hbbbb, v);
    check(32'(v), 32'd1, "R7 released by port 2");

    // R9: same-cycle release and enqueue
    rel_valid = 3'b001; rel_addr[0] = 16'hcccc;
    do_enq(7'd8, 16'hcccc, 1'b0);
    do_query(7'd2, 16'hcccc, v);
    check(32'(v), 32'd1, "R9 same-cycle release");

    // R10: retirement frees older entries
    oldest_rob = 7'd7;
    step();
    do_query(7'd4, 16'haaaa, v);
    check(32'(v), 32'd0, "R10 retired entry gone");

    // R11: redirect frees younger entries one edge later
    do_enq(7'd10, 16'hdddd, 1'b1);
    redirect_valid = 1; redirect_rob = 7'd9;
    step();
    idle_inputs();
    req_valid = 1; req_rob = 7'd12; req_addr = 16'hdddd; req_nc = 1; req_older_pending = 1;
    step();
    check(32'(obs_enq), 32'd0, "R11 younger enqueue blocked");
    idle_inputs();
    do_query(7'd7, 16'hdddd, v);
    check(32'(v), 32'd0, "R11 flushed entry gone");

    // R12: age across the wrap
    oldest_rob = 7'd60;
    step();
    do_enq(7'b1000010, 16'heeee, 1'b1);
    do_query(7'd62, 16'heeee, v);
    check(32'(v), 32'd1, "R12 younger across wrap");
    do_query(7'b1000011, 16'heeee, v);
    check(32'(v), 32'd0, "R12 older across wrap");

    // R4 full queue, R10 drain
    do_enq(7'd70, 16'hf0f0, 1'b0);
    do_enq(7'd71, 16'hf0f0, 1'b0);
    do_enq(7'd72, 16'hf0f0, 1'b0);
    check(32'(req_ready), 32'd0, "R4 full queue not ready");
    oldest_rob = 7'd80;
    step();
    check(32'(req_ready), 32'd1, "R10 drained queue ready");

    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      oldest_rob = oldest_rob + 7'($urandom_range(0, 2));
      req_valid = ($urandom_range(0, 9) < 6);
      req_rob = oldest_rob + 7'($urandom_range(1, 24));
      req_addr = pool[$urandom_range(0, 3)];
      req_nc = ($urandom_range(0, 99) < 15);
      req_older_pending = ($urandom_range(0, 9) < 8);
      req_kill = ($urandom_range(0, 9) == 0);
      for (int p = 0; p < NUM_REL; p++) begin
        rel_valid[p] = ($urandom_range(0, 99) < 15);
        rel_addr[p] = pool[$urandom_range(0, 3)];
      end
      redirect_valid = ($urandom_range(0, 99) < 3);
      redirect_rob = oldest_rob + 7'($urandom_range(0, 15));
      step();
    end
    idle_inputs();
    step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule